// File: doc/BRIEF.md
# Conditional-Block Disable Guard

This block watches a stream of 16-bit halfwords from the compact instruction-set decoder. It raises a one-cycle "undefined" flag for the uses of the conditional-block prefix instruction that are banned while the disable control is set. It recognises the prefix and checks its condition mask. It then checks the single instruction that follows the prefix against a fixed set of masked halfword patterns. Those patterns catch 32-bit instructions, branches, multiple transfers, the miscellaneous group and operations that use the program counter as an operand. A flagged instruction is undefined whether or not its condition would pass, so the block has no condition input.

The guard also keeps track of halfword boundaries. When a halfword is the first half of a 32-bit instruction, the next halfword is its tail. The tail is never decoded as a prefix or as a follower. The pending-prefix state is kept even while the disable control is low, so the control can be changed between the prefix and its follower. The flag is gated only by the control and the privilege level in the cycle the follower arrives. The flag is registered and appears in the cycle after the offending halfword is accepted.

Top module: `cond_block_guard`

## Requirements
- R1: After a synchronous reset, `undef_o` is 0 and no prefix is pending. A halfword 0xC000 sent right after reset is not flagged, even if a prefix was pending before the reset.
- R2: A halfword is a prefix only when bits [15:8] are 0xBF and bits [3:0] are nonzero. Halfwords 0xBFx0 are ordinary halfwords and open no pending state.
- R3: A prefix whose bits [3:0] are not 1000 is flagged. A prefix with bits [3:0] equal to 1000 is not flagged.
- R4: The halfword right after a prefix is flagged when bits [15:14] are 11. When such a follower is the first half of a 32-bit instruction, its tail halfword is not flagged.
- R5: The follower is flagged when it matches 1011xxxxxxxxxxxx, 10100xxxxxxxxxxx or 01001xxxxxxxxxxx (msb first).
- R6: The follower is flagged when it matches 0100x1xxx1111xxx or 010001xx1xxxx111 (msb first).
- R7: Only the first instruction after a prefix is checked. A follower that matches no pattern is not flagged, nothing after it is checked, and a follower is never itself treated as a new prefix.
- R8: When `dis_en_i` is 0 in the cycle a halfword is accepted, that halfword is not flagged, but prefix tracking goes on. A prefix accepted with `dis_en_i`=0 followed by 0xC000 with `dis_en_i`=1 is flagged.
- R9: Flags are raised only when `lvl_i` is 0 (unprivileged) or 1 (PL1). For `lvl_i` of 2 or 3 nothing is flagged.
- R10: A halfword with bits [15:13]=111 and bits [12:11]≠00 starts a 32-bit instruction. The next accepted halfword is its tail and is neither a prefix nor a follower.
- R11: `undef_o` is 1 in the cycle after a flagged halfword is accepted, and 0 after a cycle with `hw_valid_i`=0. Cycles without a valid halfword do not change the pending state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| hw_valid_i | input | 1 | A halfword is presented this cycle |
| hw_i | input | 16 | Instruction halfword, in program order |
| dis_en_i | input | 1 | Conditional-block disable control |
| lvl_i | input | LVL_W (2) | Privilege level of the stream: 0 unprivileged, 1 PL1, higher values unchecked |
| undef_o | output | 1 | Registered flag: the last accepted halfword is undefined |

## Verification
A wrong sequencing state shows at the ports within one or two halfwords. A lost pending prefix lets a forbidden follower through with no flag in the next cycle. A state that stays pending too long flags a legal second instruction. A lost halfword-boundary state turns a 32-bit tail into a false prefix, and its bad mask or its follower is flagged one cycle later. The sweeps send every prefix mask and a dense set of follower values, each behind a good prefix. Each flag is compared in the cycle after its halfword against pattern tests computed in the bench.

// File: rtl/cbg_pkg.sv
package cbg_pkg;

    localparam int HW_W  = 16;
    localparam int N_PAT = 6;

    typedef logic [HW_W-1:0] hw_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FOLLOW = 2'd1,
        ST_TAIL   = 2'd2
    } seq_st_e;

    typedef struct packed {
        hw_t mask;
        hw_t value;
    } hw_pat_t;

    typedef struct packed {
        logic is_prefix;
        logic prefix_bad;
        logic wide_head;
        logic follow_bad;
    } hw_class_t;

    // Forbidden follower shapes; order carries no priority.
    function automatic hw_pat_t pat_at(input int idx);
        hw_pat_t p;
        case (idx)
            0:       p = '{mask: 16'hC000, value: 16'hC000};
            1:       p = '{mask: 16'hF000, value: 16'hB000};
            2:       p = '{mask: 16'hF800, value: 16'hA000};
            3:       p = '{mask: 16'hF800, value: 16'h4800};
            4:       p = '{mask: 16'hF478, value: 16'h4478};
            default: p = '{mask: 16'hFC87, value: 16'h4487};
        endcase
        return p;
    endfunction

    function automatic logic is_wide_head(input hw_t h);
        return (h[15:13] == 3'b111) && (h[12:11] != 2'b00);
    endfunction

    function automatic logic is_prefix_hw(input hw_t h);
        return (h[15:8] == 8'hBF) && (h[3:0] != 4'h0);
    endfunction

    function automatic logic prefix_mask_bad(input hw_t h);
        return h[3:0] != 4'b1000;
    endfunction

endpackage

// File: rtl/cbg_hw_decode.sv
module cbg_hw_decode
    import cbg_pkg::*;
(
    input  hw_t       hw_i,
    output hw_class_t cls_o
);
    logic [N_PAT-1:0] hit;

    for (genvar g = 0; g < N_PAT; g++) begin : g_pat
        localparam hw_pat_t P = pat_at(g);
        assign hit[g] = (hw_i & P.mask) == P.value;
    end

    always_comb begin
        cls_o.is_prefix  = is_prefix_hw(hw_i);
        cls_o.prefix_bad = prefix_mask_bad(hw_i);
        cls_o.wide_head  = is_wide_head(hw_i);
        cls_o.follow_bad = |hit;
    end
endmodule

// File: rtl/cbg_seq_fsm.sv
module cbg_seq_fsm
    import cbg_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      hw_valid_i,
    input  hw_class_t cls_i,
    output seq_st_e   st_o,
    output logic      viol_o
);
    seq_st_e st_q, st_d;

    always_comb begin
        st_d   = st_q;
        viol_o = 1'b0;
        if (hw_valid_i) begin
            unique case (st_q)
                ST_IDLE: begin
                    if (cls_i.is_prefix) begin
                        viol_o = cls_i.prefix_bad;
                        st_d   = ST_FOLLOW;
                    end else if (cls_i.wide_head) begin
                        st_d = ST_TAIL;
                    end
                end
                ST_FOLLOW: begin
                    viol_o = cls_i.follow_bad;
                    st_d   = cls_i.wide_head ? ST_TAIL : ST_IDLE;
                end
                ST_TAIL: st_d = ST_IDLE;
                default: st_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= ST_IDLE;
        else       st_q <= st_d;
    end

    assign st_o = st_q;
endmodule

// File: rtl/cbg_flag_reg.sv
module cbg_flag_reg #(
    parameter int LVL_W         = 2,
    parameter int MAX_CHECK_LVL = 1
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             viol_i,
    input  logic             dis_en_i,
    input  logic [LVL_W-1:0] lvl_i,
    output logic             undef_o
);
    localparam logic [LVL_W-1:0] LVL_LIM = LVL_W'(MAX_CHECK_LVL);

    logic lvl_in_scope;
    assign lvl_in_scope = lvl_i <= LVL_LIM;

    always_ff @(posedge clk_i) begin
        if (rst_i) undef_o <= 1'b0;
        else       undef_o <= viol_i & dis_en_i & lvl_in_scope;
    end
endmodule

// File: rtl/cond_block_guard.sv
module cond_block_guard
    import cbg_pkg::*;
#(
    parameter int LVL_W         = 2,
    parameter int MAX_CHECK_LVL = 1
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             hw_valid_i,
    input  logic [15:0]      hw_i,
    input  logic             dis_en_i,
    input  logic [LVL_W-1:0] lvl_i,
    output logic             undef_o
);
    hw_class_t cls;
    seq_st_e   st_q;
    logic      viol;

    cbg_hw_decode u_decode (
        .hw_i  (hw_i),
        .cls_o (cls)
    );

    cbg_seq_fsm u_fsm (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .hw_valid_i (hw_valid_i),
        .cls_i      (cls),
        .st_o       (st_q),
        .viol_o     (viol)
    );

    cbg_flag_reg #(
        .LVL_W         (LVL_W),
        .MAX_CHECK_LVL (MAX_CHECK_LVL)
    ) u_flag (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .viol_i   (viol),
        .dis_en_i (dis_en_i),
        .lvl_i    (lvl_i),
        .undef_o  (undef_o)
    );
endmodule

// File: rtl/cbg_sva.sv
module cbg_sva
    import cbg_pkg::*;
#(
    parameter int LVL_W         = 2,
    parameter int MAX_CHECK_LVL = 1
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             hw_valid_i,
    input logic [15:0]      hw_i,
    input logic             dis_en_i,
    input logic [LVL_W-1:0] lvl_i,
    input seq_st_e          st_q,
    input logic             undef_o
);
    localparam logic [LVL_W-1:0] LVL_LIM = LVL_W'(MAX_CHECK_LVL);

    AST_RESET_CLEARS: assert property (@(posedge clk_i)
        rst_i |=> (st_q == ST_IDLE && !undef_o));  // R1

    AST_GAP_NO_FLAG: assert property (@(posedge clk_i) disable iff (rst_i)
        !hw_valid_i |=> !undef_o);  // R11

    AST_GAP_HOLDS_STATE: assert property (@(posedge clk_i) disable iff (rst_i)
        !hw_valid_i |=> $stable(st_q));  // R11

    AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        !dis_en_i |=> !undef_o);  // R8

    AST_HIGH_LVL_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        (lvl_i > LVL_LIM) |=> !undef_o);  // R9

    AST_BAD_MASK_FLAG: assert property (@(posedge clk_i) disable iff (rst_i)
        (hw_valid_i && dis_en_i && lvl_i <= LVL_LIM && st_q == ST_IDLE &&
         hw_i[15:8] == 8'hBF && hw_i[3:0] != 4'h0 && hw_i[3:0] != 4'h8)
        |=> undef_o);  // R3

    AST_TAIL_IGNORED: assert property (@(posedge clk_i) disable iff (rst_i)
        (hw_valid_i && st_q == ST_TAIL) |=> (!undef_o && st_q == ST_IDLE));  // R10

    AST_ONE_FOLLOWER: assert property (@(posedge clk_i) disable iff (rst_i)
        (hw_valid_i && st_q == ST_FOLLOW) |=> st_q != ST_FOLLOW);  // R7
endmodule

bind cond_block_guard cbg_sva #(
    .LVL_W         (LVL_W),
    .MAX_CHECK_LVL (MAX_CHECK_LVL)
) u_cbg_sva (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .hw_valid_i (hw_valid_i),
    .hw_i       (hw_i),
    .dis_en_i   (dis_en_i),
    .lvl_i      (lvl_i),
    .st_q       (st_q),
    .undef_o    (undef_o)
);

// File: tb/test_cond_block_guard.sv
`timescale 1ns/1ps
module test_cond_block_guard;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hw_valid = 1'b0;
    logic [15:0] hw = '0;
    logic        dis_en = 1'b0;
    logic [1:0]  lvl = 2'd0;
    logic        undef;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;  // 125 MHz

    cond_block_guard i_cond_block_guard (
        .clk_i      (clk),
        .rst_i      (rst),
        .hw_valid_i (hw_valid),
        .hw_i       (hw),
        .dis_en_i   (dis_en),
        .lvl_i      (lvl),
        .undef_o    (undef)
    );

    function automatic bit exp_forbid(input int h);
        if ((h >> 14) == 3)                                     return 1;
        if ((h >> 12) == 11)                                    return 1;
        if ((h >> 11) == 20)                                    return 1;
        if ((h >> 11) == 9)                                     return 1;
        if ((h >> 12) == 4 && ((h >> 10) & 1) == 1 && ((h >> 3) & 15) == 15) return 1;
        if ((h >> 10) == 17 && ((h >> 7) & 1) == 1 && (h & 7) == 7)           return 1;
        return 0;
    endfunction

    function automatic bit exp_wide(input int h);
        return (h >> 13) == 7 && ((h >> 11) & 3) != 0;
    endfunction

    task automatic check(input bit exp, input string tag, input logic [15:0] h);
        n_run++;
        if (undef !== exp) begin
            n_fail++;
            $display("FAIL %s hw=%h undef=%b expected=%b", tag, h, undef, exp);
        end
    endtask

    task automatic send(input logic [15:0] h, input bit en, input logic [1:0] l,
                        input bit exp, input string tag);
        hw_valid = 1'b1; hw = h; dis_en = en; lvl = l;
        @(posedge clk); #1;
        hw_valid = 1'b0;
        check(exp, tag, h);
    endtask

    task automatic gap(input string tag);
        hw_valid = 1'b0;
        @(posedge clk); #1;
        check(1'b0, tag, hw);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not end, undef=%b expected=finish", undef);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk); #1;
        rst = 1'b0;
        check(1'b0, "R1 reset value", hw);
        send(16'hC000, 1, 0, 0, "R1 no pending after reset");

        // reset while a prefix is pending
        send(16'hBF08, 1, 0, 0, "R3 good mask");
        rst = 1'b1; @(posedge clk); #1; rst = 1'b0;
        check(1'b0, "R1 reset clears flag", hw);
        send(16'hC000, 1, 0, 0, "R1 pending cleared by reset");

        // prefix mask sweep, each followed by a harmless halfword
        for (int i = 0; i < 256; i++) begin
            logic [15:0] p;
            p = 16'hBF00 | 16'(i);
            send(p, 1, 0, (i % 16 != 0) && (i % 16 != 8), "R3 prefix mask");
            send(16'h0000, 1, 0, 0, "R7 plain follower");
        end
        // BFx0 opens nothing
        send(16'hBF30, 1, 0, 0, "R2 hint is not prefix");
        send(16'hC000, 1, 0, 0, "R2 no follower after hint");

        // follower sweep at unprivileged level
        for (int v = 0; v < 65536; v += 3) begin
            send(16'hBF08, 1, 0, 0, "R3 good mask");
            send(16'(v), 1, 0, exp_forbid(v), "R4/R5/R6 follower sweep");
            if (exp_wide(v)) send(16'hBF04, 1, 0, 0, "R4 follower tail");
        end
        // sparser follower sweep at PL1
        for (int v = 1; v < 65536; v += 97) begin
            send(16'hBF08, 1, 1, 0, "R9 good mask PL1");
            send(16'(v), 1, 1, exp_forbid(v), "R9 follower PL1");
            if (exp_wide(v)) send(16'h0000, 1, 1, 0, "R10 tail PL1");
        end

        // directed pattern edges
        send(16'hBF08, 1, 0, 0, "R3"); send(16'hB000, 1, 0, 1, "R5 misc group");
        send(16'hBF08, 1, 0, 0, "R3"); send(16'hA7FF, 1, 0, 1, "R5 pc add");
        send(16'hBF08, 1, 0, 0, "R3"); send(16'hA800, 1, 0, 0, "R5 sp add allowed");
        send(16'hBF08, 1, 0, 0, "R3"); send(16'h4800, 1, 0, 1, "R5 pc load");
        send(16'hBF08, 1, 0, 0, "R3"); send(16'h4478, 1, 0, 1, "R6 pc source");
        send(16'hBF08, 1, 0, 0, "R3"); send(16'h4487, 1, 0, 1, "R6 pc dest");
        send(16'hBF08, 1, 0, 0, "R3"); send(16'h4470, 1, 0, 0, "R6 non-pc allowed");

        // only the first follower is checked
        send(16'hBF08, 1, 0, 0, "R3");
        send(16'h0000, 1, 0, 0, "R7 harmless follower");
        send(16'hC000, 1, 0, 0, "R7 second instruction unchecked");
        send(16'hBF08, 1, 0, 0, "R3");
        send(16'hBF08, 1, 0, 1, "R7 prefix as follower flagged");
        send(16'hC000, 1, 0, 0, "R7 follower opens no new block");

        // disable control low
        send(16'hBF04, 0, 0, 0, "R8 bad mask, control off");
        send(16'hC000, 0, 0, 0, "R8 follower, control off");
        send(16'hBF08, 0, 0, 0, "R8 prefix tracked while off");
        send(16'hC000, 1, 0, 1, "R8 control raised at follower");

        // level scope
        for (int l = 0; l < 4; l++) begin
            send(16'hBF08, 1, 2'(l), 0, "R9 good mask");
            send(16'hC000, 1, 2'(l), l < 2, "R9 level gate");
        end

        // 32-bit halfword boundary outside a block
        send(16'hE800, 1, 0, 0, "R10 wide head idle");
        send(16'hBF04, 1, 0, 0, "R10 tail not a prefix");
        send(16'hC000, 1, 0, 0, "R10 no follower after tail");
        send(16'hE000, 1, 0, 0, "R10 16-bit branch is not wide");
        send(16'hBF04, 1, 0, 1, "R10 prefix right after narrow");
        send(16'h0000, 1, 0, 0, "R7 plain follower");
        send(16'hBF08, 1, 0, 0, "R3");
        send(16'hF000, 1, 0, 1, "R4 wide follower");
        send(16'hBF04, 1, 0, 0, "R4 wide follower tail");
        send(16'hC000, 1, 0, 0, "R4 after tail unchecked");

        // gaps keep the pending state and clear the flag
        send(16'hBF08, 1, 0, 0, "R3");
        gap("R11 gap"); gap("R11 gap"); gap("R11 gap");
        send(16'hC000, 1, 0, 1, "R11 follower after gaps");
        gap("R11 flag lasts one cycle");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule